// File: doc/BRIEF.md
# General-Purpose I/O Register Controller

This block is the register front end of a 32-pin general-purpose I/O peripheral. An APB slave port selects one of ten 32-bit word registers. Most of them hold one bit per pin: output value, output enable, output-source select, interrupt enable, trigger polarity, external-clock enable and clock-edge select. One more is a control word that holds the master interrupt enable. The pad drivers take the output value and the per-pin enables straight from these registers. For each pin, the source-select bit chooses whether the pad follows software's output bit or a bit of an external auxiliary bus.

A separate input-sampling block sits beside this one. It gets the polarity, external-clock and clock-edge selects from here. It sends back the sampled pin values, which a read of the input word returns, and a per-pin event vector. Each enabled event sets a sticky status bit. The interrupt line is the OR of the status bits, gated by the master enable. Every transfer completes without wait states.

Top module: `gpio_regbank`

## Requirements
- R1: `pready` is high in every cycle, so every transfer completes in its first access-phase cycle.
- R2: After reset every register reads zero, so `padOe`, `padOut` (with `auxIn` low), `trigPos`, `extClkEn`, `negEdgeSel` and `irq` are all zero.
- R3: A register is written only on the clock edge that ends a cycle with `psel`, `penable` and `pwrite` all high. A setup-phase cycle (`penable` low) changes nothing, and neither does a cycle with `psel` low.
- R4: Word offset 0x00 reads the present `sampledIn` value. Writes to it are ignored.
- R5: Offset 0x08 is the output-enable word. Bit n drives `padOe[n]`, and 1 makes pin n an output.
- R6: Offset 0x14 is the source-select word and offset 0x04 is the output word. `padOut[n]` is `auxIn[n]` when select bit n is 1, and output bit n when it is 0.
- R7: Offset 0x1C is the interrupt-status word. In each cycle, bit n becomes set when `intEventIn[n]` is high while bit n of the interrupt-enable word (offset 0x0C) is 1. A write loads the written value. An event arriving in the same cycle as the write is still recorded.
- R8: `irq` is high exactly when control bit 0 is 1 and at least one status bit is set.
- R9: The polarity (0x10), external-clock enable (0x20) and clock-edge select (0x24) words read back what was written and drive `trigPos`, `extClkEn` and `negEdgeSel`.
- R10: A read of an offset at or above 0x28, or of an address whose low two bits are not zero, returns zero. A write there changes no register. `prdata` is zero whenever `psel` is low or `pwrite` is high.
- R11: The control word at 0x18 stores only bit 0 (master interrupt enable). Its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| paddr | input | ADDR_W | Byte address of the register |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | PINS | Write data |
| prdata | output | PINS | Read data |
| pready | output | 1 | Transfer complete, always high |
| sampledIn | input | PINS | Sampled pin values from the input sampler |
| intEventIn | input | PINS | Per-pin trigger events from the input sampler |
| auxIn | input | PINS | Alternative pad source per pin |
| padOut | output | PINS | Pad output values |
| padOe | output | PINS | Pad output enables |
| trigPos | output | PINS | Per-pin trigger polarity to the sampler |
| extClkEn | output | PINS | Per-pin external sampling clock enable |
| negEdgeSel | output | PINS | Per-pin sampling edge select |
| irq | output | 1 | Interrupt request |

## Verification
The output mux is driven with the output word and the auxiliary bus both set to complementary patterns and both changing, while a half-and-half select word is held. Any pin taking the wrong source then shows as a flipped bit. Writes are also attempted in setup-only cycles, with `psel` low, at the read-only input word and at unmapped or unaligned addresses. These cases separate a correct access-phase decode from one that writes too early or too widely. The interrupt path is exercised with events on enabled and disabled pins, with the master enable off and then on, and with a status write landing in the same cycle as a new event. This shows whether the enable masking, the gating and the merge of a write with a new event each behave as specified.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int NUM_REGS = 10;

  typedef enum logic [3:0] {
    REG_IN    = 4'd0,
    REG_OUT   = 4'd1,
    REG_OE    = 4'd2,
    REG_INTE  = 4'd3,
    REG_PTRIG = 4'd4,
    REG_AUX   = 4'd5,
    REG_CTRL  = 4'd6,
    REG_INTS  = 4'd7,
    REG_ECLK  = 4'd8,
    REG_NEC   = 4'd9
  } regIdx_e;

  // registers that are plain storage with no side function
  localparam logic [NUM_REGS-1:0] PLAIN_RW = 10'b11_0011_1110;

  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic [3:0] idx;
  } busCmd_t;

endpackage

// File: rtl/gpio_regbank_ctrl.sv
module gpio_regbank_ctrl
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  output busCmd_t           cmd
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordAddr;
  logic              hit;

  always_comb begin
    wordAddr  = paddr[ADDR_W-1:2];
    hit       = (paddr[1:0] == 2'b00) && (32'(wordAddr) < NUM_REGS);
    cmd.idx   = hit ? 4'(wordAddr) : 4'd0;
    cmd.wrStb = psel && penable && pwrite && hit;
    cmd.rdStb = psel && !pwrite && hit;
  end
endmodule

// File: rtl/gpio_regbank_dp.sv
module gpio_regbank_dp
  import gpio_regbank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  busCmd_t         cmd,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] sampledIn,
  input  logic [PINS-1:0] intEventIn,
  input  logic [PINS-1:0] auxIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] trigPos,
  output logic [PINS-1:0] extClkEn,
  output logic [PINS-1:0] negEdgeSel,
  output logic            irq
);
  logic [PINS-1:0] rwBank [NUM_REGS];
  logic [PINS-1:0] intStat;
  logic            masterIe;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    if (PLAIN_RW[g]) begin : g_store
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rwBank[g] <= '0;
        else if (cmd.wrStb && cmd.idx == 4'(g)) rwBank[g] <= wdata;
      end
    end else begin : g_none
      assign rwBank[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) masterIe <= 1'b0;
    else if (cmd.wrStb && cmd.idx == REG_CTRL) masterIe <= wdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStat <= '0;
    else intStat <= ((cmd.wrStb && cmd.idx == REG_INTS) ? wdata : intStat)
                    | (intEventIn & rwBank[REG_INTE]);
  end

  always_comb begin
    rdata = '0;
    if (cmd.rdStb) begin
      case (cmd.idx)
        REG_IN:   rdata = sampledIn;
        REG_CTRL: rdata = {{(PINS-1){1'b0}}, masterIe};
        REG_INTS: rdata = intStat;
        default:  rdata = rwBank[cmd.idx];
      endcase
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pad
    assign padOut[p] = rwBank[REG_AUX][p] ? auxIn[p] : rwBank[REG_OUT][p];
  end

  assign padOe      = rwBank[REG_OE];
  assign trigPos    = rwBank[REG_PTRIG];
  assign extClkEn   = rwBank[REG_ECLK];
  assign negEdgeSel = rwBank[REG_NEC];
  assign irq        = masterIe && (|intStat);
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  output logic              pready,
  input  logic [PINS-1:0]   sampledIn,
  input  logic [PINS-1:0]   intEventIn,
  input  logic [PINS-1:0]   auxIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   trigPos,
  output logic [PINS-1:0]   extClkEn,
  output logic [PINS-1:0]   negEdgeSel,
  output logic              irq
);
  busCmd_t cmd;

  assign pready = 1'b1;

  gpio_regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite), .cmd(cmd)
  );

  gpio_regbank_dp #(.PINS(PINS)) u_dp (
    .clk(pclk), .rstN(presetn), .cmd(cmd), .wdata(pwdata),
    .sampledIn(sampledIn), .intEventIn(intEventIn), .auxIn(auxIn),
    .rdata(prdata), .padOut(padOut), .padOe(padOe), .trigPos(trigPos),
    .extClkEn(extClkEn), .negEdgeSel(negEdgeSel), .irq(irq)
  );
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 6
) (
  input logic              pclk,
  input logic              presetn,
  input logic [ADDR_W-1:0] paddr,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [PINS-1:0]   pwdata,
  input logic [PINS-1:0]   prdata,
  input logic              pready,
  input logic [PINS-1:0]   sampledIn,
  input logic [PINS-1:0]   padOe
);
  logic wrAccess;
  assign wrAccess = psel && penable && pwrite;

  AST_READY_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
    pready); // R1

  AST_OE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !wrAccess |=> $stable(padOe)); // R3

  AST_IN_READBACK: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == '0) |-> prdata == sampledIn); // R4

  AST_OE_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAccess && paddr == ADDR_W'(8)) |=> padOe == $past(pwdata)); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && 32'(paddr) >= 40) |-> prdata == '0); // R10
endmodule

bind gpio_regbank gpio_regbank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel),
  .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
  .pready(pready), .sampledIn(sampledIn), .padOe(padOe)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 32;
  localparam int AW = 6;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [PINS-1:0] pwdata = '0, sampledIn = '0, intEventIn = '0, auxIn = '0;
  logic [PINS-1:0] prdata, padOut, padOe, trigPos, extClkEn, negEdgeSel;
  logic pready, irq;

  int vectors = 0, miscompares = 0;
  string tag = "R2";

  // behavioural reference state
  logic [PINS-1:0] m [10];
  logic mIe;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_regbank #(.PINS(PINS), .ADDR_W(AW)) dut (.*);

  task automatic cmp(string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit hitAddr(logic [AW-1:0] a);
    return a[1:0] == 2'b00 && int'(a[AW-1:2]) < 10;
  endfunction

  task automatic modelEdge();
    logic [PINS-1:0] ev, ints;
    int idx;
    if (!presetn) begin
      for (int i = 0; i < 10; i++) m[i] = '0;
      mIe = 0;
      return;
    end
    ev = intEventIn & m[3];
    ints = m[7];
    idx = int'(paddr[AW-1:2]);
    if (psel && penable && pwrite && hitAddr(paddr)) begin
      if (idx == 6) mIe = pwdata[0];
      else if (idx == 7) ints = pwdata;
      else if (idx != 0) m[idx] = pwdata;
    end
    m[7] = ints | ev;
  endtask

  function automatic logic [PINS-1:0] expRd();
    int idx = int'(paddr[AW-1:2]);
    if (!(psel && !pwrite && hitAddr(paddr))) return '0;
    if (idx == 0) return sampledIn;
    if (idx == 6) return {{(PINS-1){1'b0}}, mIe};
    return m[idx];
  endfunction

  task automatic step();
    @(posedge pclk);
    modelEdge();
    #1;
    cmp("prdata", prdata, expRd());
    cmp("pready", {31'b0, pready}, 32'd1);
    cmp("padOut", padOut, (m[5] & auxIn) | (~m[5] & m[1]));
    cmp("padOe", padOe, m[2]);
    cmp("trigPos", trigPos, m[4]);
    cmp("extClkEn", extClkEn, m[8]);
    cmp("negEdgeSel", negEdgeSel, m[9]);
    cmp("irq", {31'b0, irq}, {31'b0, mIe && (|m[7])});
  endtask

  task automatic idle();
    psel = 0; penable = 0; pwrite = 0;
    step();
  endtask

  task automatic apbWrite(logic [AW-1:0] a, logic [PINS-1:0] d);
    paddr = a; pwdata = d; psel = 1; pwrite = 1; penable = 0;
    step();
    penable = 1;
    step();
    idle();
  endtask

  task automatic apbRead(logic [AW-1:0] a);
    paddr = a; psel = 1; pwrite = 0; penable = 0;
    step();
    penable = 1;
    step();
    idle();
  endtask

  task automatic readAll();
    for (int i = 0; i < 10; i++) apbRead(AW'(i * 4));
  endtask

  initial begin
    for (int i = 0; i < 10; i++) m[i] = '0;
    mIe = 0;
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tag = "R2";
    auxIn = 32'hFFFF_FFFF;
    repeat (3) step();
    presetn = 1;
    auxIn = '0;
    sampledIn = 32'hA5A5_5A5A;
    idle();
    readAll();

    tag = "R5";
    apbWrite(6'h08, 32'hFFFF_0000);
    apbRead(6'h08);

    tag = "R6";
    apbWrite(6'h04, 32'h1234_5678);
    apbWrite(6'h14, 32'h0000_FFFF);
    auxIn = 32'hEDCB_A987; idle();
    auxIn = 32'h0F0F_F0F0; idle();
    apbWrite(6'h04, 32'hEDCB_A987);
    auxIn = 32'h1234_5678; idle();
    apbRead(6'h14);

    tag = "R3";
    paddr = 6'h04; pwdata = 32'hDEAD_BEEF; psel = 1; pwrite = 1; penable = 0;
    step(); step();
    psel = 0; penable = 1; step();
    paddr = 6'h08; step();
    idle();
    apbRead(6'h04);
    apbRead(6'h08);

    tag = "R4";
    apbWrite(6'h00, 32'hFFFF_FFFF);
    sampledIn = 32'h0000_0001; apbRead(6'h00);
    sampledIn = 32'h8000_0000; apbRead(6'h00);
    readAll();

    tag = "R9";
    apbWrite(6'h10, 32'hCAFE_0001);
    apbWrite(6'h20, 32'h0BAD_F00D);
    apbWrite(6'h24, 32'h7654_3210);
    apbRead(6'h10); apbRead(6'h20); apbRead(6'h24);

    tag = "R11";
    apbWrite(6'h18, 32'hFFFF_FFFE);
    apbRead(6'h18);
    apbWrite(6'h18, 32'hFFFF_FFFF);
    apbRead(6'h18);
    apbWrite(6'h18, 32'h0);

    tag = "R7";
    apbWrite(6'h0C, 32'h0000_000F);
    intEventIn = 32'h0000_00FF; idle();
    intEventIn = '0; idle();
    apbRead(6'h1C);

    tag = "R8";
    apbWrite(6'h18, 32'h1);
    idle();
    apbWrite(6'h1C, 32'h0);
    idle();

    tag = "R7";
    paddr = 6'h1C; pwdata = 32'h0000_0100; psel = 1; pwrite = 1; penable = 0;
    step();
    penable = 1; intEventIn = 32'h0000_0002;
    step();
    intEventIn = '0;
    idle();
    apbRead(6'h1C);

    tag = "R8";
    apbWrite(6'h18, 32'h0); idle();
    apbWrite(6'h1C, 32'h0); idle();

    tag = "R10";
    apbRead(6'h28); apbRead(6'h3C); apbRead(6'h05); apbRead(6'h26);
    apbWrite(6'h2C, 32'hFFFF_FFFF);
    apbWrite(6'h09, 32'h0);
    apbWrite(6'h06, 32'h5555_5555);
    readAll();
    paddr = 6'h04; psel = 1; pwrite = 1; penable = 1; pwdata = m[1]; step();
    idle();
    psel = 0; pwrite = 0; paddr = 6'h04; step();

    tag = "R1";
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule